// File: doc/BRIEF.md
# Multiplexed Digit Display Refresh Controller

This block keeps a sixteen-position character store for a multiplexed digit display and scans it out continuously. Each scan step presents the index of one digit on a select output and that digit's byte, split into an upper and a lower nibble, on two data outputs. A programmable hold count sets how many clock cycles each digit stays lit before the scan moves on. No host action is needed to keep the display refreshed.

A host loads characters through a one-cycle write strobe. A mode input chooses between two entry styles. Left entry writes at a running pointer that then advances one digit to the right. Right entry works like a calculator: every stored character moves one place to the left, the leftmost character is lost, and the new character enters at the rightmost digit. A synchronous clear input empties the store and rewinds the pointer.

Top module: `disp_refresh_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the scan index, both nibble outputs, every stored byte and the write pointer all become 0, so the first digit shown after reset is index 0 with value 0x00.
- R2: With `hold_cycles` = N, each digit index stays on `scan_sel` for exactly N+1 clock cycles, and the index steps by one in the order 0, 1, ..., 15, 0.
- R3: `disp_hi` carries bits [7:4] and `disp_lo` carries bits [3:0] of the byte at the digit on `scan_sel`. All three outputs change on the same clock edge and stay constant between scan steps.
- R4: With `entry_mode` = 0 (left entry), a write stores `wr_data` at the write pointer and advances the pointer by one, so the next character lands one digit further right (digit 0 is the leftmost).
- R5: In left entry the write pointer wraps from 15 to 0, so a seventeenth write after a clear overwrites digit 0.
- R6: With `entry_mode` = 1 (right entry), a write moves every byte from digit i+1 to digit i, discards the old digit 0, and places `wr_data` at digit 15. The write pointer is unchanged.
- R7: `clr` high at a rising edge sets all sixteen bytes to 0x00 and the write pointer to 0. It takes priority over a write in the same cycle and does not disturb the scan.
- R8: A scan step samples the store as it stood before that edge. A write accepted on the same edge as the step to its digit does not appear until the next visit to that digit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of the character store and write pointer |
| entry_mode | input | 1 | 0 = left entry, 1 = right (calculator) entry |
| wr_en | input | 1 | One-cycle write strobe |
| wr_data | input | 8 | Character byte to write |
| hold_cycles | input | PRESC_W (16) | Each digit is held hold_cycles+1 cycles |
| scan_sel | output | SEL_W (4) | Index of the digit being refreshed |
| disp_hi | output | 4 | Upper nibble of the selected byte |
| disp_lo | output | 4 | Lower nibble of the selected byte |

## Verification
The bench checks the pointer wrap from 15 to 0. A design that saturated the pointer, or let it run past the store, would show the seventeenth character at digit 15 or lose it instead of replacing digit 0. In right entry the bench confirms that the old leftmost byte drops out, that nothing wraps back to digit 15, and that the left-entry pointer is left where it was; an implementation that rotated the store or moved the pointer would show the wrong character after a later left write. It also times a write onto the exact edge where the scan reaches that digit, where a design reading the store after the update would show the new byte one visit early. Finally, it checks a clear issued together with a write, which must leave digit 0 empty.

// File: rtl/disp_pkg.sv
package disp_pkg;

    // Character width and the nibble split used on the display outputs
    localparam int GLYPH_W = 8;
    localparam int NIB_W   = GLYPH_W / 2;

    // A stored character, viewed as the two nibbles the outputs carry
    typedef struct packed {
        logic [NIB_W-1:0] hi;
        logic [NIB_W-1:0] lo;
    } glyph_t;

    typedef enum logic {
        ENTRY_LEFT  = 1'b0,
        ENTRY_RIGHT = 1'b1
    } entry_mode_e;

    // Operation applied to the character store in one cycle
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_CLEAR = 2'd1,
        OP_STORE = 2'd2,
        OP_SHIFT = 2'd3
    } mem_op_e;

    // Clear wins over a write; the mode picks store-at-pointer or shift
    function automatic mem_op_e decode_op(input logic clr,
                                          input logic wr,
                                          input entry_mode_e mode);
        mem_op_e op;
        if (clr)
            op = OP_CLEAR;
        else if (!wr)
            op = OP_IDLE;
        else if (mode == ENTRY_RIGHT)
            op = OP_SHIFT;
        else
            op = OP_STORE;
        return op;
    endfunction

endpackage

// File: rtl/disp_mem.sv
module disp_mem
    import disp_pkg::*;
#(
    parameter  int DIGITS = 16,
    localparam int AW     = $clog2(DIGITS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  mem_op_e              op,
    input  glyph_t               din,
    output glyph_t [DIGITS-1:0]  img,
    output logic   [AW-1:0]      wr_ptr
);

    localparam logic [AW-1:0] LAST = AW'(DIGITS - 1);

    logic [AW-1:0] ptr_inc;

    always_comb begin
        ptr_inc = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
    end

    // Left-entry pointer: advances on store, rewinds on clear, holds on shift
    always_ff @(posedge clk) begin
        if (rst || op == OP_CLEAR)
            wr_ptr <= '0;
        else if (op == OP_STORE)
            wr_ptr <= ptr_inc;
    end

    // One register per digit; its shift source is the right-hand neighbour,
    // or the incoming character for the rightmost digit
    for (genvar g = 0; g < DIGITS; g++) begin : g_cell
        glyph_t cell_q;
        glyph_t shift_src;

        if (g == DIGITS - 1) begin : g_tail
            assign shift_src = din;
        end else begin : g_body
            assign shift_src = img[g+1];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                cell_q <= '0;
            end else begin
                case (op)
                    OP_CLEAR: cell_q <= '0;
                    OP_STORE: if (wr_ptr == AW'(g)) cell_q <= din;
                    OP_SHIFT: cell_q <= shift_src;
                    default:  ;
                endcase
            end
        end

        assign img[g] = cell_q;
    end

endmodule

// File: rtl/disp_scan.sv
module disp_scan #(
    parameter  int DIGITS  = 16,
    parameter  int PRESC_W = 16,
    localparam int AW      = $clog2(DIGITS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PRESC_W-1:0] hold,
    output logic               step,
    output logic [AW-1:0]      pos_next
);

    localparam logic [AW-1:0] LAST = AW'(DIGITS - 1);

    logic [PRESC_W-1:0] dwell_q;
    logic [AW-1:0]      pos_q;

    // >= so that lowering the hold count mid-digit cannot strand the counter
    assign step     = (dwell_q >= hold);
    assign pos_next = step ? ((pos_q == LAST) ? '0 : pos_q + 1'b1) : pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dwell_q <= '0;
            pos_q   <= '0;
        end else begin
            dwell_q <= step ? '0 : dwell_q + 1'b1;
            pos_q   <= pos_next;
        end
    end

endmodule

// File: rtl/disp_drive.sv
module disp_drive
    import disp_pkg::*;
#(
    parameter  int DIGITS = 16,
    localparam int AW     = $clog2(DIGITS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                step,
    input  logic   [AW-1:0]     pos_next,
    input  glyph_t [DIGITS-1:0] img,
    output logic   [AW-1:0]     sel,
    output glyph_t              view
);

    glyph_t picked;

    // Reads the store before this edge's update lands
    always_comb begin
        picked = img[pos_next];
    end

    // Index and both nibbles share one register stage
    always_ff @(posedge clk) begin
        if (rst) begin
            sel  <= '0;
            view <= '0;
        end else if (step) begin
            sel  <= pos_next;
            view <= picked;
        end
    end

endmodule

// File: rtl/disp_refresh_ctrl.sv
module disp_refresh_ctrl
    import disp_pkg::*;
#(
    parameter  int DIGITS  = 16,
    parameter  int PRESC_W = 16,
    localparam int SEL_W   = $clog2(DIGITS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               entry_mode,
    input  logic               wr_en,
    input  logic [GLYPH_W-1:0] wr_data,
    input  logic [PRESC_W-1:0] hold_cycles,
    output logic [SEL_W-1:0]   scan_sel,
    output logic [NIB_W-1:0]   disp_hi,
    output logic [NIB_W-1:0]   disp_lo
);

    glyph_t [DIGITS-1:0] mem_img;
    logic   [SEL_W-1:0]  wr_ptr;
    mem_op_e             mem_op;
    logic                step;
    logic   [SEL_W-1:0]  pos_next;
    glyph_t              view;

    assign mem_op = decode_op(clr, wr_en, entry_mode_e'(entry_mode));

    disp_mem #(.DIGITS(DIGITS)) u_mem (
        .clk    (clk),
        .rst    (rst),
        .op     (mem_op),
        .din    (glyph_t'(wr_data)),
        .img    (mem_img),
        .wr_ptr (wr_ptr)
    );

    disp_scan #(.DIGITS(DIGITS), .PRESC_W(PRESC_W)) u_scan (
        .clk      (clk),
        .rst      (rst),
        .hold     (hold_cycles),
        .step     (step),
        .pos_next (pos_next)
    );

    disp_drive #(.DIGITS(DIGITS)) u_drive (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .pos_next (pos_next),
        .img      (mem_img),
        .sel      (scan_sel),
        .view     (view)
    );

    assign disp_hi = view.hi;
    assign disp_lo = view.lo;

endmodule

// File: rtl/disp_refresh_chk.sv
module disp_refresh_chk
    import disp_pkg::*;
#(
    parameter int DIGITS = 16,
    parameter int SEL_W  = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                clr,
    input logic                entry_mode,
    input logic                wr_en,
    input logic [GLYPH_W-1:0]  wr_data,
    input logic [SEL_W-1:0]    scan_sel,
    input logic [NIB_W-1:0]    disp_hi,
    input logic [NIB_W-1:0]    disp_lo,
    input logic [SEL_W-1:0]    wr_ptr,
    input glyph_t [DIGITS-1:0] mem_img
);

    localparam logic [SEL_W-1:0] LAST = SEL_W'(DIGITS - 1);

    logic armed = 1'b0;
    glyph_t [DIGITS-1:0] prev_img;

    always_ff @(posedge clk) begin
        armed    <= 1'b1;
        prev_img <= mem_img;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!armed)
        $fell(rst) |-> (scan_sel == '0 && disp_hi == '0 && disp_lo == '0 && wr_ptr == '0));

    // R2
    scan_advance_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        (!$past(rst) && !$stable(scan_sel)) |->
            scan_sel == (($past(scan_sel) == LAST) ? '0 : $past(scan_sel) + 1'b1));

    // R3
    nibble_hold_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        (!$past(rst) && $stable(scan_sel)) |-> ($stable(disp_hi) && $stable(disp_lo)));

    // R4
    left_store_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        (wr_en && !clr && !entry_mode) |=>
            (mem_img[$past(wr_ptr)] == glyph_t'($past(wr_data))));

    // R5
    left_wrap_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        (wr_en && !clr && !entry_mode && wr_ptr == LAST) |=> (wr_ptr == '0));

    // R6
    right_shift_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        (wr_en && !clr && entry_mode) |=>
            (mem_img[DIGITS-1] == glyph_t'($past(wr_data)) &&
             mem_img[0] == $past(mem_img[1]) && $stable(wr_ptr)));

    // R7
    clear_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        clr |=> (wr_ptr == '0 && mem_img == '0));

    // R8
    refresh_sample_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        (!$past(rst) && !$stable(scan_sel)) |-> ({disp_hi, disp_lo} == prev_img[scan_sel]));

endmodule

bind disp_refresh_ctrl disp_refresh_chk #(.DIGITS(DIGITS), .SEL_W(SEL_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .clr        (clr),
    .entry_mode (entry_mode),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .scan_sel   (scan_sel),
    .disp_hi    (disp_hi),
    .disp_lo    (disp_lo),
    .wr_ptr     (wr_ptr),
    .mem_img    (mem_img)
);

// File: tb/disp_refresh_ctrl_test.sv
module disp_refresh_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr = 1'b0;
    logic        entry_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [15:0] hold_cycles = 16'd3;
    logic [3:0]  scan_sel;
    logic [3:0]  disp_hi;
    logic [3:0]  disp_lo;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [7:0] model [16];
    int mptr = 0;

    disp_refresh_ctrl uut (
        .clk         (clk),
        .rst         (rst),
        .clr         (clr),
        .entry_mode  (entry_mode),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .hold_cycles (hold_cycles),
        .scan_sel    (scan_sel),
        .disp_hi     (disp_hi),
        .disp_lo     (disp_lo)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            errors++;
            $display("FAIL watchdog: actual cycles=%0d expected fewer", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        mptr = 0;
    endtask

    // Called at a negedge; leaves at the next negedge
    task automatic write_byte(input logic [7:0] d, input logic right);
        wr_en = 1'b1;
        wr_data = d;
        entry_mode = right;
        @(negedge clk);
        wr_en = 1'b0;
        if (right) begin
            for (int i = 0; i < 15; i++) model[i] = model[i+1];
            model[15] = d;
        end else begin
            model[mptr] = d;
            mptr = (mptr + 1) % 16;
        end
    endtask

    task automatic do_clear(input logic with_write, input logic [7:0] d);
        clr = 1'b1;
        wr_en = with_write;
        wr_data = d;
        entry_mode = 1'b0;
        @(negedge clk);
        clr = 1'b0;
        wr_en = 1'b0;
        model_clear();
    endtask

    // Waits for a fresh arrival of digit k, then checks index and nibbles
    task automatic observe_digit(input int k, input logic [7:0] exp, input string req);
        int guard = 0;
        while (scan_sel == 4'(k) && guard < 600) begin @(negedge clk); guard++; end
        while (scan_sel != 4'(k) && guard < 600) begin @(negedge clk); guard++; end
        check(req, "scan index", 32'(scan_sel), 32'(k));
        check(req, "upper nibble", 32'(disp_hi), 32'(exp[7:4]));
        check(req, "lower nibble", 32'(disp_lo), 32'(exp[3:0]));
    endtask

    task automatic sweep(input string req);
        for (int k = 0; k < 16; k++) observe_digit(k, model[k], req);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        hold_cycles = 16'd3;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_clear();
        @(negedge clk);
        // R1: first cycle after reset shows digit 0 holding 0x00
        check("R1", "scan index", 32'(scan_sel), 32'd0);
        check("R1", "upper nibble", 32'(disp_hi), 32'd0);
        check("R1", "lower nibble", 32'(disp_lo), 32'd0);
        hold_cycles = 16'd1;
        sweep("R1");
    endtask

    task automatic measure_hold(input logic [15:0] h);
        logic [3:0] s0;
        int n;
        int guard;
        hold_cycles = h;
        for (int w = 0; w < 2; w++) begin
            s0 = scan_sel;
            guard = 0;
            while (scan_sel == s0 && guard < 200) begin @(negedge clk); guard++; end
        end
        s0 = scan_sel;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (scan_sel == s0 && n < 200);
        // R2: dwell equals hold+1, next index is one higher
        check("R2", "dwell cycles", 32'(n), 32'(h) + 32'd1);
        check("R2", "next index", 32'(scan_sel), 32'(4'(s0 + 4'd1)));
    endtask

    task automatic t_prescale();
        logic [3:0] prev;
        measure_hold(16'd3);
        measure_hold(16'd0);
        measure_hold(16'd6);
        hold_cycles = 16'd0;
        @(negedge clk);
        prev = scan_sel;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            // R2: index order with wrap 15 -> 0
            check("R2", "scan order", 32'(scan_sel), 32'(4'(prev + 4'd1)));
            prev = scan_sel;
        end
        hold_cycles = 16'd1;
    endtask

    task automatic t_left();
        @(negedge clk);
        do_clear(1'b0, 8'h00);
        write_byte(8'h12, 1'b0);
        write_byte(8'h34, 1'b0);
        write_byte(8'hA5, 1'b0);
        write_byte(8'h0F, 1'b0);
        sweep("R4");
        // R3: 0xA5 splits into upper 0xA and lower 0x5
        observe_digit(2, 8'hA5, "R3");
    endtask

    task automatic t_wrap();
        @(negedge clk);
        do_clear(1'b0, 8'h00);
        for (int i = 0; i < 17; i++) write_byte(8'(8'h40 + i), 1'b0);
        // R5: digit 0 now holds the seventeenth character 0x50
        observe_digit(0, 8'h50, "R5");
        sweep("R5");
    endtask

    task automatic t_right();
        @(negedge clk);
        do_clear(1'b0, 8'h00);
        write_byte(8'h11, 1'b1);
        write_byte(8'h22, 1'b1);
        write_byte(8'h33, 1'b1);
        observe_digit(15, 8'h33, "R6");
        sweep("R6");
        for (int i = 0; i < 16; i++) write_byte(8'(8'h80 + i), 1'b1);
        // R6: the earlier characters have all been pushed out on the left
        observe_digit(0, 8'h80, "R6");
        sweep("R6");
        // R6: pointer untouched, so a left write lands at digit 0
        write_byte(8'hC3, 1'b0);
        observe_digit(0, 8'hC3, "R6");
    endtask

    task automatic t_clear();
        @(negedge clk);
        write_byte(8'h5A, 1'b0);
        do_clear(1'b0, 8'h00);
        sweep("R7");
        write_byte(8'h21, 1'b0);
        write_byte(8'h22, 1'b0);
        // R7: clear wins over a simultaneous write
        do_clear(1'b1, 8'hEE);
        observe_digit(0, 8'h00, "R7");
        write_byte(8'h99, 1'b0);
        observe_digit(0, 8'h99, "R7");
        observe_digit(1, 8'h00, "R7");
    endtask

    task automatic t_collision();
        int guard = 0;
        hold_cycles = 16'd3;
        @(negedge clk);
        do_clear(1'b0, 8'h00);
        while (scan_sel == 4'd15 && guard < 400) begin @(negedge clk); guard++; end
        while (scan_sel != 4'd15 && guard < 400) begin @(negedge clk); guard++; end
        // Dwell counter is 0 here; the step to digit 0 is four edges away
        repeat (3) @(negedge clk);
        write_byte(8'h7E, 1'b0);
        // R8: step and write shared an edge, old byte shown
        check("R8", "scan index", 32'(scan_sel), 32'd0);
        check("R8", "upper nibble", 32'(disp_hi), 32'd0);
        check("R8", "lower nibble", 32'(disp_lo), 32'd0);
        observe_digit(0, 8'h7E, "R8");
        hold_cycles = 16'd1;
    endtask

    initial begin
        model_clear();
        t_reset();
        t_prescale();
        t_left();
        t_wrap();
        t_right();
        t_clear();
        t_collision();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule